// File: doc/BRIEF.md
# Power-Fail Guarded Byte SRAM

This block is a byte-wide static memory with active-low chip select, output enable and write enable, sampled on a system clock, and guarded by a supply monitor. A digitized supply code is compared against two programmable thresholds. One is the guard level, below which the memory stops responding. The other is the retention level, below which the memory is treated as running from its backup cell. The array contents survive every power mode, so data written before a brown-out can be read back once the supply has recovered.

A host drives the control strobes in the style of an asynchronous SRAM. A write opens when both select and write enable are low. It is committed, with the address and data last sampled while it was open, on the clock edge where either strobe has returned high. Reads are ripple-through: the stored byte appears on the output in the same cycle as the address. After a supply dip, normal operation resumes only when the supply code has stayed at or above the guard level for a programmable number of clock edges. The array depth is set by `ADDR_W`: the default of 12 gives 4096 bytes, and `ADDR_W = 15` gives the full 32768-byte organisation. A build option derives the retention level from the guard level minus a fixed code offset, instead of taking it from a port.

Top module: `pfsram_ctrl`

## Requirements
- R1: The array holds 2^ADDR_W bytes. A completed write to any address, including address 0 and the all-ones address, is returned by a later read of that address.
- R2: While `ce_n` is high, `dq_oe` is 0 and no write reaches the array, whatever `oe_n` and `we_n` do.
- R3: While `ce_n` and `we_n` are both low, the block is writing and `dq_oe` is 0, even with `oe_n` low.
- R4: With `ce_n` and `oe_n` low and `we_n` high in normal mode, `dq_oe` is 1 in the same cycle and `dq_out` carries the byte stored at `addr`. With `oe_n` high instead, `dq_oe` is 0.
- R5: A write is committed on the first clock edge at which `ce_n` or `we_n` is sampled high after both were low. It stores the address and `dq_in` sampled on the last edge at which both were low. Either strobe may end the write.
- R6: While a read is driving, lowering `we_n` turns `dq_oe` off in that same cycle.
- R7: In any cycle where `vcode < thr_pfd`, `dq_oe` is 0 and no write can change the array. The inputs of that cycle are already ignored, before the mode register updates.
- R8: `pwr_mode` becomes 2'b10 (backup) on the edge after `vcode < thr_so`. It becomes 2'b01 (guard) when `thr_so <= vcode < thr_pfd`. Array contents are unchanged across both modes.
- R9: With `SO_TRACK = 1`, the retention level is `thr_pfd - SO_OFFSET`, saturating at 0, and the `thr_so` port is not used.
- R10: A write still open when the supply code drops below `thr_pfd` is dropped and never reaches the array.
- R11: From guard or backup mode, `pwr_mode` returns to 2'b00 on the `hold_cycles`-th consecutive edge with `vcode >= thr_pfd` (a value of 0 acts as 1). Any edge below the guard level restarts the count.
- R12: The mode encoding is 2'b00 normal, 2'b01 guard, 2'b10 backup, and 2'b11 never occurs. During reset `pwr_mode` is 2'b01 and `dq_oe` is 0, so the hold time of R11 applies after reset.
- R13: `batt_ok` equals `batt_sense` as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Write data from host |
| dq_out | output | DATA_W | Read data toward host |
| dq_oe | output | 1 | Drive enable for the data bus |
| vcode | input | VC_W | Digitized supply level |
| thr_pfd | input | VC_W | Guard (deselect) threshold |
| thr_so | input | VC_W | Retention (backup) threshold |
| hold_cycles | input | HOLD_W | Recovery qualification length |
| batt_sense | input | 1 | Backup cell health input |
| pwr_mode | output | 2 | Power mode code |
| batt_ok | output | 1 | Registered backup cell health |

## Verification
The bench targets a write caught by a supply dip mid-transfer. A design that commits on the strobe release regardless of supply would store the byte, and the later read-back shows it. It checks that the guard acts in the very cycle the code drops: a design gated only by the registered mode would still drive the bus for one cycle. It also checks the recovery count restart after a single low edge: a counter that is not cleared returns to normal too early. Finally it checks the threshold edges (code equal to each level) and, on a second instance, the derived retention level, where an off-by-one compare or a missing subtraction shows up as the wrong mode code.

// File: rtl/pfsram_pkg.sv
package pfsram_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_GUARD = 2'b01,
    PM_KEEP  = 2'b10
  } pwr_mode_e;

  // strict "below threshold" compare on a common width
  function automatic logic code_below(input logic [15:0] code, input logic [15:0] lvl);
    return code < lvl;
  endfunction

  // retention level derived from guard level, saturating at zero
  function automatic logic [15:0] so_derive(input logic [15:0] pfd, input logic [15:0] off);
    return (pfd > off) ? (pfd - off) : 16'd0;
  endfunction

  // true once the qualified count reaches the programmed length (0 acts as 1)
  function automatic logic hold_done(input logic [15:0] cnt_nx, input logic [15:0] hold);
    logic [15:0] lim;
    lim = (hold == 16'd0) ? 16'd1 : hold;
    return cnt_nx >= lim;
  endfunction

endpackage

// File: rtl/pfsram_pwr_mon.sv
module pfsram_pwr_mon
  import pfsram_pkg::*;
#(
  parameter int VC_W      = 8,
  parameter int HOLD_W    = 8,
  parameter bit SO_TRACK  = 1'b0,
  parameter int SO_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VC_W-1:0]   vcode,
  input  logic [VC_W-1:0]   thr_pfd,
  input  logic [VC_W-1:0]   thr_so,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic [1:0]        mode,
  output logic              below_pfd,
  output logic [VC_W-1:0]   thr_so_eff
);

  pwr_mode_e         mode_q;
  logic [HOLD_W-1:0] cnt_q;
  logic              below_so;
  logic              qual_done;

  generate
    if (SO_TRACK) begin : g_so_derived
      assign thr_so_eff = VC_W'(so_derive(16'(thr_pfd), 16'(SO_OFFSET)));
    end else begin : g_so_port
      assign thr_so_eff = thr_so;
    end
  endgenerate

  assign below_pfd = code_below(16'(vcode), 16'(thr_pfd));
  assign below_so  = code_below(16'(vcode), 16'(thr_so_eff));
  assign qual_done = hold_done(16'(cnt_q) + 16'd1, 16'(hold_cycles));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= PM_GUARD;
      cnt_q  <= '0;
    end else if (below_so) begin
      mode_q <= PM_KEEP;
      cnt_q  <= '0;
    end else if (below_pfd) begin
      mode_q <= PM_GUARD;
      cnt_q  <= '0;
    end else if (mode_q != PM_RUN) begin
      if (qual_done) begin
        mode_q <= PM_RUN;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + HOLD_W'(1);
      end
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/pfsram_wr_seq.sv
module pfsram_wr_seq #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              protect,
  output logic              drive_en,
  output logic              wr_commit,
  output logic              wr_abort,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic wr_live;
  logic wr_open_q;

  // overlap of select and write strobe, only while supply is good
  assign wr_live  = ~ce_n & ~we_n & ~protect;
  assign drive_en = ~ce_n & ~oe_n & we_n & ~protect;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_open_q <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_open_q <= wr_live;
      if (wr_live) begin
        wr_addr <= addr;
        wr_data <= dq_in;
      end
    end
  end

  assign wr_commit = wr_open_q & ~wr_live & ~protect;
  assign wr_abort  = wr_open_q & protect;

endmodule

// File: rtl/pfsram_array.sv
module pfsram_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wen,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/pfsram_ctrl.sv
module pfsram_ctrl
  import pfsram_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int VC_W      = 8,
  parameter int HOLD_W    = 8,
  parameter bit SO_TRACK  = 1'b0,
  parameter int SO_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [VC_W-1:0]   vcode,
  input  logic [VC_W-1:0]   thr_pfd,
  input  logic [VC_W-1:0]   thr_so,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              batt_sense,
  output logic [1:0]        pwr_mode,
  output logic              batt_ok
);

  // named internal events, observed by the bound checker
  logic              below_pfd;
  logic              protect;
  logic              wr_commit;
  logic              wr_abort;
  logic [VC_W-1:0]   thr_so_eff;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  pfsram_pwr_mon #(
    .VC_W(VC_W), .HOLD_W(HOLD_W), .SO_TRACK(SO_TRACK), .SO_OFFSET(SO_OFFSET)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .vcode(vcode), .thr_pfd(thr_pfd), .thr_so(thr_so),
    .hold_cycles(hold_cycles), .mode(pwr_mode), .below_pfd(below_pfd),
    .thr_so_eff(thr_so_eff)
  );

  // guard acts on the raw compare at once, and holds until the mode recovers
  assign protect = below_pfd | (pwr_mode != PM_RUN);

  pfsram_wr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .protect(protect), .drive_en(dq_oe),
    .wr_commit(wr_commit), .wr_abort(wr_abort), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  pfsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .wen(wr_commit), .waddr(wr_addr), .wdata(wr_data),
    .raddr(addr), .rdata(dq_out)
  );

  always_ff @(posedge clk) begin
    batt_ok <= batt_sense;
  end

endmodule

// File: rtl/pfsram_ctrl_chk.sv
module pfsram_ctrl_chk #(
  parameter int VC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce_n,
  input logic            we_n,
  input logic            dq_oe,
  input logic            protect,
  input logic            wr_commit,
  input logic            wr_abort,
  input logic [1:0]      pwr_mode,
  input logic [VC_W-1:0] vcode,
  input logic [VC_W-1:0] thr_pfd,
  input logic [VC_W-1:0] thr_so_eff,
  input logic            batt_sense,
  input logic            batt_ok
);

  assert_idle_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dq_oe);

  assert_write_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |-> !dq_oe);

  assert_guard_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    protect |-> !dq_oe);

  assert_commit_needs_power_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (pwr_mode == 2'b00 && vcode >= thr_pfd));

  assert_backup_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode < thr_so_eff) |=> (pwr_mode == 2'b10));

  assert_guard_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode < thr_pfd && vcode >= thr_so_eff) |=> (pwr_mode == 2'b01));

  assert_abort_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |-> !wr_commit);

  assert_recover_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b00 && $past(pwr_mode) != 2'b00) |-> ($past(vcode) >= $past(thr_pfd)));

  assert_mode_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode != 2'b11);

  assert_batt_follow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (batt_ok == $past(batt_sense)));

endmodule

bind pfsram_ctrl pfsram_ctrl_chk #(.VC_W(VC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .dq_oe(dq_oe),
  .protect(protect), .wr_commit(wr_commit), .wr_abort(wr_abort),
  .pwr_mode(pwr_mode), .vcode(vcode), .thr_pfd(thr_pfd), .thr_so_eff(thr_so_eff),
  .batt_sense(batt_sense), .batt_ok(batt_ok)
);

// File: tb/pfsram_ctrl_tb_top.sv
module pfsram_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  vcode = 8'd150, thr_pfd = 8'd100, thr_so = 8'd80;
  logic [7:0]  hold_cycles = 8'd4;
  logic        batt_sense = 1'b1;
  logic [7:0]  dq_out, lv_dq_out;
  logic        dq_oe, lv_dq_oe, batt_ok, lv_batt_ok;
  logic [1:0]  pwr_mode, lv_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { bit oe; logic [7:0] d; string tag; } bus_item_t;
  bus_item_t sbq[$];

  always #2 clk = ~clk;

  pfsram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .vcode(vcode), .thr_pfd(thr_pfd),
    .thr_so(thr_so), .hold_cycles(hold_cycles), .batt_sense(batt_sense),
    .pwr_mode(pwr_mode), .batt_ok(batt_ok)
  );

  pfsram_ctrl #(.SO_TRACK(1'b1), .SO_OFFSET(8)) dut_lv_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .dq_in(dq_in), .dq_out(lv_dq_out), .dq_oe(lv_dq_oe), .vcode(vcode), .thr_pfd(thr_pfd),
    .thr_so(8'd0), .hold_cycles(hold_cycles), .batt_sense(batt_sense),
    .pwr_mode(lv_mode), .batt_ok(lv_batt_ok)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit c, input bit o, input bit w,
                     input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = a; dq_in = d;
  endtask

  task automatic expect_bus(input bit oe, input logic [7:0] d, input string tag);
    bus_item_t it;
    it.oe = oe; it.d = d; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b1, 12'h0, 8'h0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, 1'b0, a, d);
    expect_bus(1'b0, 8'h0, "R3 no drive while writing");
    cyc(1'b0, 1'b1, 1'b1, a, d);
    cyc(1'b1, 1'b1, 1'b1, a, d);
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] d, input string tag);
    cyc(1'b0, 1'b0, 1'b1, a, 8'h0);
    expect_bus(1'b1, d, tag);
    cyc(1'b1, 1'b1, 1'b1, a, 8'h0);
  endtask

  // monitor: compares bus outputs against queued expectations after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        bus_item_t it;
        it = sbq.pop_front();
        chk({it.tag, " dq_oe"}, 32'(dq_oe), 32'(it.oe));
        if (it.oe) chk({it.tag, " dq_out"}, 32'(dq_out), 32'(it.d));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset mode", 32'(pwr_mode), 32'h1);
    chk("R12 reset no drive", 32'(dq_oe), 32'h0);
    rst_n = 1'b1;
    idle(3);
    chk("R11 post-reset still guarded", 32'(pwr_mode), 32'h1);
    idle(1);
    chk("R11 post-reset normal", 32'(pwr_mode), 32'h0);

    // R1 basic storage, including end addresses
    wr(12'h000, 8'h11);
    wr(12'hFFF, 8'hEE);
    wr(12'h2A5, 8'h5C);
    rd(12'h000, 8'h11, "R1 addr 0");
    rd(12'hFFF, 8'hEE, "R1 top addr");
    rd(12'h2A5, 8'h5C, "R1 mid addr");

    // R4 output enable high: no drive
    cyc(1'b0, 1'b1, 1'b1, 12'h2A5, 8'h0);
    expect_bus(1'b0, 8'h0, "R4 oe_n high");
    idle(1);

    // R3 write with oe_n low
    cyc(1'b0, 1'b0, 1'b0, 12'h100, 8'h77);
    expect_bus(1'b0, 8'h0, "R3 write with oe_n low");
    cyc(1'b0, 1'b0, 1'b1, 12'h100, 8'h0);
    idle(1);
    rd(12'h100, 8'h77, "R3 stored");

    // R5 write ended by select, last sampled data wins
    cyc(1'b0, 1'b1, 1'b0, 12'h200, 8'hAA);
    cyc(1'b0, 1'b1, 1'b0, 12'h200, 8'hBB);
    cyc(1'b1, 1'b1, 1'b0, 12'h200, 8'hCC);
    idle(1);
    rd(12'h200, 8'hBB, "R5 end by ce_n");

    // R6 falling we_n during a read cuts drive
    wr(12'h300, 8'h31);
    cyc(1'b0, 1'b0, 1'b1, 12'h300, 8'h0);
    expect_bus(1'b1, 8'h31, "R6 read before");
    cyc(1'b0, 1'b0, 1'b0, 12'h300, 8'h62);
    expect_bus(1'b0, 8'h0, "R6 drive off on we_n");
    cyc(1'b0, 1'b0, 1'b1, 12'h300, 8'h0);
    idle(1);
    rd(12'h300, 8'h62, "R6 write landed");

    // R2 deselected strobes ignored
    cyc(1'b1, 1'b0, 1'b0, 12'h300, 8'h99);
    expect_bus(1'b0, 8'h0, "R2 deselect no drive");
    cyc(1'b1, 1'b0, 1'b1, 12'h300, 8'h99);
    idle(1);
    rd(12'h300, 8'h62, "R2 no write while deselected");

    // R7 guard acts in the same cycle
    cyc(1'b0, 1'b0, 1'b1, 12'h300, 8'h0);
    vcode = 8'd99;
    expect_bus(1'b0, 8'h0, "R7 same-cycle guard");
    cyc(1'b0, 1'b1, 1'b0, 12'h300, 8'h13);
    chk("R7 mode guard", 32'(pwr_mode), 32'h1);
    expect_bus(1'b0, 8'h0, "R7 no drive in guard");
    cyc(1'b0, 1'b1, 1'b1, 12'h300, 8'h13);
    cyc(1'b1, 1'b1, 1'b1, 12'h0, 8'h0);
    vcode = 8'd100;
    idle(4);
    chk("R11 recover at threshold", 32'(pwr_mode), 32'h0);
    rd(12'h300, 8'h62, "R7 write blocked");

    // R10 write aborted by dip
    wr(12'h400, 8'h21);
    cyc(1'b0, 1'b1, 1'b0, 12'h400, 8'h5A);
    cyc(1'b0, 1'b1, 1'b0, 12'h400, 8'h5A);
    vcode = 8'd90;
    cyc(1'b1, 1'b1, 1'b1, 12'h400, 8'h5A);
    vcode = 8'd150;
    idle(4);
    rd(12'h400, 8'h21, "R10 aborted write");

    // R11 dip restarts recovery count
    idle(1);
    vcode = 8'd90;
    idle(1);
    vcode = 8'd150;
    idle(3);
    chk("R11 count 3 of 4", 32'(pwr_mode), 32'h1);
    vcode = 8'd90;
    idle(1);
    vcode = 8'd150;
    idle(3);
    chk("R11 restarted count", 32'(pwr_mode), 32'h1);
    idle(1);
    chk("R11 normal after restart", 32'(pwr_mode), 32'h0);

    // R8 backup entry and retention, boundary at thr_so
    wr(12'h500, 8'hA5);
    vcode = 8'd80;
    idle(1);
    chk("R8 at retention level is guard", 32'(pwr_mode), 32'h1);
    vcode = 8'd79;
    idle(1);
    chk("R8 below retention is backup", 32'(pwr_mode), 32'h2);
    vcode = 8'd50;
    idle(2);
    chk("R8 stays backup", 32'(pwr_mode), 32'h2);
    vcode = 8'd90;
    idle(1);
    chk("R8 backup to guard", 32'(pwr_mode), 32'h1);
    vcode = 8'd150;
    idle(4);
    chk("R8 recovered", 32'(pwr_mode), 32'h0);
    rd(12'h500, 8'hA5, "R8 contents retained");

    // R9 derived retention level = 100 - 8 = 92 on second instance
    vcode = 8'd92;
    idle(1);
    chk("R9 derived level boundary", 32'(lv_mode), 32'h1);
    chk("R9 port level guard", 32'(pwr_mode), 32'h1);
    vcode = 8'd91;
    idle(1);
    chk("R9 below derived level", 32'(lv_mode), 32'h2);
    chk("R9 port level unaffected", 32'(pwr_mode), 32'h1);
    vcode = 8'd150;
    idle(4);
    chk("R9 derived instance recovers", 32'(lv_mode), 32'h0);

    // R13 battery flag
    batt_sense = 1'b0;
    idle(1);
    chk("R13 batt low", 32'(batt_ok), 32'h0);
    batt_sense = 1'b1;
    idle(1);
    chk("R13 batt good", 32'(batt_ok), 32'h1);

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule